// File: doc/BRIEF.md
# Square-Wave Interval Timer

This block is a 14-bit interval timer that counts rising edges of a slow external timer input and turns them into a square wave or a one-input-period low pulse. A length value and a two-bit output mode are written as two bytes into a staging register. A two-bit command then starts the timer, stops it at once, or stops it at the end of the current period. A start issued while the timer runs takes effect only at the next terminal count. A sticky terminal-count flag is kept for a status reader, and reading the status clears it.

Internally the counter steps down by two in each half of the output period. The starting value of the first half is rounded up to an even number, so an odd length makes the high half one input period longer than the low half. The timer input is sampled on the system clock, and only its detected rising edges advance the count.

Top module: `sqwave_timer`

## Requirements
- R1: A write with `len_lo_we` stores `wdata` as length bits 7..0. A write with `len_hi_we` stores `wdata[5:0]` as length bits 13..8 and `wdata[7:6]` as the mode {pulse, reload}: 00 single square wave, 01 continuous square wave, 10 single pulse, 11 continuous pulses.
- R2: `tin` passes through a two-flop synchronizer. Only a rising edge advances the timer, once per edge, however long the input stays high.
- R3: In the square modes with length N, `tout` is high for the first ceil(N/2) input edges after start and low for the next floor(N/2) edges. Terminal count is the N-th edge.
- R4: The reload modes (mode bit 6 = 1) restart a full period at every terminal count. The single modes stop at the first terminal count, and a stopped square mode holds `tout` high.
- R5: In the pulse modes `tout` goes low at terminal count and returns high on the next input rising edge. At all other times it is high.
- R6: Command 11 (start) while idle copies the staged length and mode and sets `active`. A staged length below 2 makes the start ignored, and `active` stays low.
- R7: Command 11 while running leaves the current period on its old length and mode. The staged values take over from the next terminal count.
- R8: Command 01 stops a running timer at once, with `active` low and `tout` high. While idle it does nothing.
- R9: Command 10 lets the current period reach terminal count and then stops. While idle it does nothing. Command 00 does nothing.
- R10: Writing the length bytes while running does not change the running period until a start command is given.
- R11: `tc_flag` goes high at terminal count and stays high until a `stat_rd` pulse clears it. If terminal count and `stat_rd` fall in the same cycle, the flag stays high.
- R12: Reset stops the timer and clears `tc_flag` and any pending command, with `tout` high. Input edges after reset do not start counting without a start command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tin | input | 1 | Timer input, asynchronous to clk |
| wdata | input | 8 | Byte for the length/mode staging register |
| len_lo_we | input | 1 | Write strobe for length bits 7..0 |
| len_hi_we | input | 1 | Write strobe for length bits 13..8 and mode |
| cmd_we | input | 1 | Command strobe |
| cmd | input | 2 | Command: 00 nop, 01 stop now, 10 stop at terminal count, 11 start |
| stat_rd | input | 1 | Status read pulse, clears the terminal-count flag |
| tout | output | 1 | Timer output waveform |
| tc_flag | output | 1 | Sticky terminal-count flag |
| active | output | 1 | High while the timer is counting |

## Verification
The bench checks odd lengths, where a design that splits the period evenly would make the high half one edge too short. It checks length 2, the shortest valid period, and lengths 1 and 0, which a careless start would accept and run. It checks a start issued mid-period: a design that loaded the new values at once would cut the old period short. It checks staging writes made during a run, which a leaky design would apply without a start. Further cases cover a status read that lands in the same cycle as terminal count, where a clear-wins flag would lose the event, and a long high input, which a level-counting design would count many times.

// File: rtl/sqt_pkg.sv
package sqt_pkg;

  // Command codes presented on the command strobe.
  typedef enum logic [1:0] {
    CMD_NOP        = 2'b00,
    CMD_HALT       = 2'b01,
    CMD_HALT_AT_TC = 2'b10,
    CMD_GO         = 2'b11
  } tcmd_e;

  // Output mode: pulse selects pulse shape, reload selects continuous.
  typedef struct packed {
    logic pulse;
    logic reload;
  } tmode_t;

endpackage

// File: rtl/sqt_edge_sync.sv
module sqt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tin,
  output logic tin_rise
);

  logic [STAGES-1:0] sh_q;
  logic              prev_q;
  logic [STAGES-1:0] sh_n;

  always_comb begin
    sh_n = {sh_q[STAGES-2:0], tin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= sh_n;
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign tin_rise = sh_q[STAGES-1] & ~prev_q;

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tin_rise |=> !tin_rise); // R2

endmodule

// File: rtl/sqt_len_regs.sv
module sqt_len_regs #(
  parameter int CW = 14,
  parameter int BW = 8
) (
  input  logic             clk,
  input  logic [BW-1:0]    wdata,
  input  logic             lo_we,
  input  logic             hi_we,
  output logic [CW-1:0]    stg_len,
  output sqt_pkg::tmode_t  stg_mode
);

  localparam int HI_CNT = CW - BW;

  logic [BW-1:0]     lo_q;
  logic [HI_CNT-1:0] hi_q;
  sqt_pkg::tmode_t   mode_q;

  // Staging registers carry no reset value.
  always_ff @(posedge clk) begin
    if (lo_we) begin
      lo_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (hi_we) begin
      hi_q   <= wdata[HI_CNT-1:0];
      mode_q <= wdata[BW-1 -: 2];
    end
  end

  assign stg_len  = {hi_q, lo_q};
  assign stg_mode = mode_q;

endmodule

// File: rtl/sqt_status.sv
module sqt_status (
  input  logic clk,
  input  logic rst_n,
  input  logic tc,
  input  logic clr,
  output logic flag
);

  logic flag_q;
  logic flag_n;

  always_comb begin
    if (tc) begin
      flag_n = 1'b1;
    end else if (clr) begin
      flag_n = 1'b0;
    end else begin
      flag_n = flag_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_n;
    end
  end

  assign flag = flag_q;

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    tc |=> flag); // R11
  AST_FLAG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !tc) |=> !flag); // R11

endmodule

// File: rtl/sqt_core.sv
module sqt_core #(
  parameter int CW = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tin_rise,
  input  logic             cmd_we,
  input  logic [1:0]       cmd,
  input  logic [CW-1:0]    stg_len,
  input  sqt_pkg::tmode_t  stg_mode,
  output logic             tc,
  output logic             running,
  output logic             tout
);
  import sqt_pkg::*;

  localparam int              CNTW = CW + 1;
  localparam logic [CNTW-1:0] TWO  = CNTW'(2);

  // Start value of the high half: length rounded up to even.
  function automatic logic [CNTW-1:0] first_half(input logic [CW-1:0] l);
    return {1'b0, l} + CNTW'(l[0]);
  endfunction

  // Start value of the low half: length rounded down to even.
  function automatic logic [CNTW-1:0] second_half(input logic [CW-1:0] l);
    return {1'b0, l[CW-1:1], 1'b0};
  endfunction

  logic            run_q, run_n;
  logic            half_q, half_n;
  logic            pulse_lo_q, pulse_lo_n;
  logic            start_pend_q, start_pend_n;
  logic            stop_pend_q, stop_pend_n;
  logic [CNTW-1:0] cnt_q, cnt_n;
  logic [CW-1:0]   act_len_q, act_len_n;
  tmode_t          act_mode_q, act_mode_n;
  logic            tc_c;
  logic            stg_ok;
  tcmd_e           cmd_e;

  assign stg_ok = (stg_len >= CW'(2));
  assign cmd_e  = tcmd_e'(cmd);

  always_comb begin
    run_n        = run_q;
    half_n       = half_q;
    pulse_lo_n   = pulse_lo_q;
    start_pend_n = start_pend_q;
    stop_pend_n  = stop_pend_q;
    cnt_n        = cnt_q;
    act_len_n    = act_len_q;
    act_mode_n   = act_mode_q;
    tc_c         = 1'b0;

    if (tin_rise) begin
      pulse_lo_n = 1'b0;
    end

    if (run_q && tin_rise) begin
      if (cnt_q == TWO) begin
        if (!half_q) begin
          half_n = 1'b1;
          cnt_n  = second_half(act_len_q);
        end else begin
          tc_c   = 1'b1;
          half_n = 1'b0;
          if (act_mode_q.pulse) begin
            pulse_lo_n = 1'b1;
          end
          if (start_pend_q) begin
            if (stg_ok) begin
              act_len_n  = stg_len;
              act_mode_n = stg_mode;
              cnt_n      = first_half(stg_len);
            end else begin
              run_n = 1'b0;
            end
          end else if (stop_pend_q || !act_mode_q.reload) begin
            run_n = 1'b0;
          end else begin
            cnt_n = first_half(act_len_q);
          end
          start_pend_n = 1'b0;
          stop_pend_n  = 1'b0;
        end
      end else begin
        cnt_n = cnt_q - TWO;
      end
    end

    if (cmd_we) begin
      unique case (cmd_e)
        CMD_HALT: begin
          if (run_q) begin
            run_n        = 1'b0;
            pulse_lo_n   = 1'b0;
            start_pend_n = 1'b0;
            stop_pend_n  = 1'b0;
          end
        end
        CMD_HALT_AT_TC: begin
          if (run_q && run_n) begin
            stop_pend_n  = 1'b1;
            start_pend_n = 1'b0;
          end
        end
        CMD_GO: begin
          if (!run_q) begin
            if (stg_ok) begin
              run_n        = 1'b1;
              half_n       = 1'b0;
              pulse_lo_n   = 1'b0;
              act_len_n    = stg_len;
              act_mode_n   = stg_mode;
              cnt_n        = first_half(stg_len);
              start_pend_n = 1'b0;
              stop_pend_n  = 1'b0;
            end
          end else if (run_n && stg_ok) begin
            start_pend_n = 1'b1;
            stop_pend_n  = 1'b0;
          end
        end
        default: begin
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q        <= 1'b0;
      half_q       <= 1'b0;
      pulse_lo_q   <= 1'b0;
      start_pend_q <= 1'b0;
      stop_pend_q  <= 1'b0;
    end else begin
      run_q        <= run_n;
      half_q       <= half_n;
      pulse_lo_q   <= pulse_lo_n;
      start_pend_q <= start_pend_n;
      stop_pend_q  <= stop_pend_n;
    end
  end

  // Datapath registers are only meaningful while running: no reset.
  always_ff @(posedge clk) begin
    cnt_q      <= cnt_n;
    act_len_q  <= act_len_n;
    act_mode_q <= act_mode_n;
  end

  assign tc      = tc_c;
  assign running = run_q;
  assign tout    = act_mode_q.pulse ? ~pulse_lo_q : (run_q ? ~half_q : 1'b1);

  AST_CNT_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (!cnt_q[0] && cnt_q >= TWO)); // R3
  AST_HALT_NOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd == 2'b01) |=> !run_q); // R8
  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_lo_q && tin_rise) |=> !pulse_lo_q); // R5
  AST_NO_SHORT_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> (act_len_q >= CW'(2))); // R6
  AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !cmd_we && !tc_c) |=> ($stable(act_len_q) && $stable(act_mode_q))); // R10

endmodule

// File: rtl/sqwave_timer.sv
module sqwave_timer #(
  parameter int CW          = 14,
  parameter int BW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tin,
  input  logic [BW-1:0] wdata,
  input  logic          len_lo_we,
  input  logic          len_hi_we,
  input  logic          cmd_we,
  input  logic [1:0]    cmd,
  input  logic          stat_rd,
  output logic          tout,
  output logic          tc_flag,
  output logic          active
);

  logic [1:0]      rsync_q;
  logic            rst_n_s;
  logic            tin_rise;
  logic            tc;
  logic [CW-1:0]   stg_len;
  sqt_pkg::tmode_t stg_mode;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= 2'b00;
    end else begin
      rsync_q <= {rsync_q[0], 1'b1};
    end
  end
  assign rst_n_s = rsync_q[1];

  sqt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .tin      (tin),
    .tin_rise (tin_rise)
  );

  sqt_len_regs #(.CW(CW), .BW(BW)) u_len (
    .clk      (clk),
    .wdata    (wdata),
    .lo_we    (len_lo_we),
    .hi_we    (len_hi_we),
    .stg_len  (stg_len),
    .stg_mode (stg_mode)
  );

  sqt_core #(.CW(CW)) u_core (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .tin_rise (tin_rise),
    .cmd_we   (cmd_we),
    .cmd      (cmd),
    .stg_len  (stg_len),
    .stg_mode (stg_mode),
    .tc       (tc),
    .running  (active),
    .tout     (tout)
  );

  sqt_status u_stat (
    .clk   (clk),
    .rst_n (rst_n_s),
    .tc    (tc),
    .clr   (stat_rd),
    .flag  (tc_flag)
  );

endmodule

// File: tb/test_sqwave_timer.sv
module test_sqwave_timer;

  logic       clk;
  logic       rst_n;
  logic       tin;
  logic [7:0] wdata;
  logic       len_lo_we;
  logic       len_hi_we;
  logic       cmd_we;
  logic [1:0] cmd;
  logic       stat_rd;
  logic       tout;
  logic       tc_flag;
  logic       active;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done  = 0;

  sqwave_timer i_sqwave_timer (
    .clk(clk), .rst_n(rst_n), .tin(tin), .wdata(wdata),
    .len_lo_we(len_lo_we), .len_hi_we(len_hi_we),
    .cmd_we(cmd_we), .cmd(cmd), .stat_rd(stat_rd),
    .tout(tout), .tc_flag(tc_flag), .active(active)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // ---------------- expected-value functions ----------------
  function automatic bit f_tc(input int mode, input int n, input int k);
    return (k > 0) && (k % n == 0) && (((mode & 1) != 0) || k == n);
  endfunction

  function automatic bit f_active(input int mode, input int n, input int k);
    return ((mode & 1) != 0) ? 1'b1 : (k < n);
  endfunction

  function automatic bit f_tout(input int mode, input int n, input int k);
    bit single;
    single = ((mode & 1) == 0);
    if ((mode & 2) != 0) begin
      if (single && k > n) return 1'b1;
      return !f_tc(mode, n, k);
    end
    if (single && k >= n) return 1'b1;
    return (k % n) < ((n + 1) / 2);
  endfunction

  // ---------------- check and drive tasks ----------------
  task automatic chk(input logic got, input logic expv, input string req, input string what);
    n_cmp++;
    if (got !== expv) begin
      n_bad++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, got, expv);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic pulse_tin(input int high_clks);
    @(negedge clk) tin = 1'b1;
    repeat (high_clks) @(negedge clk);
    tin = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic put_cmd(input logic [1:0] c);
    @(negedge clk) begin cmd_we = 1'b1; cmd = c; end
    @(negedge clk) cmd_we = 1'b0;
  endtask

  task automatic read_stat();
    @(negedge clk) stat_rd = 1'b1;
    @(negedge clk) stat_rd = 1'b0;
  endtask

  task automatic stage(input int mode, input int n);
    @(negedge clk) begin len_lo_we = 1'b1; wdata = n[7:0]; end
    @(negedge clk) begin len_lo_we = 1'b0; len_hi_we = 1'b1; wdata = {mode[1:0], n[13:8]}; end
    @(negedge clk) len_hi_we = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  // Fresh start from idle, then run 'edges' input edges with full checking.
  task automatic run_seq(input int mode, input int n, input int edges, input int rd_at, input string req);
    bit fexp;
    put_cmd(2'b01);
    read_stat();
    stage(mode, n);
    put_cmd(2'b11);
    chk(active, 1'b1, req, "active after start");
    chk(tout, f_tout(mode, n, 0), req, "tout at start");
    fexp = 1'b0;
    for (int k = 1; k <= edges; k++) begin
      pulse_tin(4);
      if (f_tc(mode, n, k)) fexp = 1'b1;
      chk(tout, f_tout(mode, n, k), req, $sformatf("tout mode %0d len %0d edge %0d", mode, n, k));
      chk(active, f_active(mode, n, k), req, $sformatf("active edge %0d", k));
      chk(tc_flag, fexp, "R11", $sformatf("flag edge %0d", k));
      if (k == rd_at) begin
        read_stat();
        fexp = 1'b0;
        chk(tc_flag, 1'b0, "R11", "flag after status read");
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b1; tin = 1'b0; wdata = '0; len_lo_we = 1'b0; len_hi_we = 1'b0;
    cmd_we = 1'b0; cmd = 2'b00; stat_rd = 1'b0;
    do_reset();

    // R12: reset state
    chk(active, 1'b0, "R12", "active after reset");
    chk(tout, 1'b1, "R12", "tout after reset");
    chk(tc_flag, 1'b0, "R12", "flag after reset");
    pulse_tin(4);
    chk(active, 1'b0, "R12", "no count without start");

    // R8/R9: stop commands while idle do nothing; R6 short lengths ignored
    put_cmd(2'b01);
    chk(active, 1'b0, "R8", "stop-now idle");
    put_cmd(2'b10);
    chk(active, 1'b0, "R9", "stop-at-tc idle");
    put_cmd(2'b00);
    chk(active, 1'b0, "R9", "nop idle");
    stage(1, 1);
    put_cmd(2'b11);
    chk(active, 1'b0, "R6", "length 1 rejected");
    stage(1, 0);
    put_cmd(2'b11);
    chk(active, 1'b0, "R6", "length 0 rejected");

    // R3 odd single square wave, R4 single stop
    run_seq(0, 9, 11, -1, "R3");
    chk(active, 1'b0, "R4", "single square stopped");
    chk(tout, 1'b1, "R4", "single square idles high");
    // R3/R4 shortest continuous
    run_seq(1, 2, 6, 3, "R4");
    // R5 single and continuous pulses
    run_seq(2, 5, 7, -1, "R5");
    run_seq(3, 3, 10, 4, "R5");

    // R1: length using the high byte (259), single pulse
    put_cmd(2'b01);
    stage(2, 259);
    put_cmd(2'b11);
    for (int k = 1; k <= 258; k++) pulse_tin(2);
    chk(active, 1'b1, "R1", "long length still running at 258");
    chk(tout, 1'b1, "R1", "no pulse before 259");
    pulse_tin(2);
    chk(tout, 1'b0, "R1", "pulse at edge 259");
    chk(active, 1'b0, "R1", "single pulse stopped");

    // R2: long high input counts once
    put_cmd(2'b01);
    stage(1, 2);
    put_cmd(2'b11);
    pulse_tin(30);
    chk(tout, 1'b0, "R2", "one edge from long high");
    pulse_tin(4);
    chk(tout, 1'b1, "R2", "second edge");

    // R11: status read in the same cycle as terminal count
    read_stat();
    pulse_tin(4);
    @(negedge clk) tin = 1'b1;
    repeat (2) @(negedge clk);
    stat_rd = 1'b1;
    @(negedge clk) stat_rd = 1'b0;
    chk(tc_flag, 1'b1, "R11", "set wins over read");
    tin = 1'b0;
    repeat (5) @(negedge clk);

    // R8: stop now while running
    put_cmd(2'b01);
    chk(active, 1'b0, "R8", "stop-now halts");
    chk(tout, 1'b1, "R8", "tout high after stop");

    // R9: stop after terminal count
    read_stat();
    stage(1, 4);
    put_cmd(2'b11);
    pulse_tin(4);
    put_cmd(2'b10);
    for (int k = 2; k <= 3; k++) begin
      pulse_tin(4);
      chk(active, 1'b1, "R9", $sformatf("still running edge %0d", k));
    end
    pulse_tin(4);
    chk(active, 1'b0, "R9", "stopped at terminal count");
    chk(tout, 1'b1, "R9", "idle high after stop");
    chk(tc_flag, 1'b1, "R9", "flag at final count");
    pulse_tin(4);
    chk(active, 1'b0, "R9", "stays stopped");

    // R10 and R7: staging while running, then deferred start
    stage(1, 4);
    put_cmd(2'b11);
    for (int k = 1; k <= 2; k++) pulse_tin(4);
    stage(3, 6);
    for (int k = 3; k <= 8; k++) begin
      pulse_tin(4);
      chk(tout, f_tout(1, 4, k), "R10", $sformatf("staged write ignored edge %0d", k));
    end
    put_cmd(2'b11);
    for (int k = 9; k <= 12; k++) begin
      pulse_tin(4);
      chk(tout, f_tout(1, 4, k), "R7", $sformatf("old period kept edge %0d", k));
    end
    for (int j = 1; j <= 13; j++) begin
      pulse_tin(4);
      chk(tout, f_tout(3, 6, j), "R7", $sformatf("new settings edge %0d", j));
    end

    // R12: reset mid-run
    do_reset();
    chk(active, 1'b0, "R12", "reset stops run");
    chk(tout, 1'b1, "R12", "reset tout high");
    chk(tc_flag, 1'b0, "R12", "reset clears flag");

    // Random runs: R3, R4, R5
    for (int it = 0; it < 12; it++) begin
      int m, n, e, r;
      m = int'($urandom_range(0, 3));
      n = int'($urandom_range(2, 17));
      e = n * 2 + int'($urandom_range(0, 3));
      r = ($urandom_range(0, 1) == 1) ? int'($urandom_range(1, e)) : -1;
      run_seq(m, n, e, r, ((m & 2) != 0) ? "R5" : "R3");
    end

    finish_run();
  end

endmodule